// File: doc/BRIEF.md
# Prescaled Interval and Event Timer

This block is the timer of a small microcontroller core. An 8-bit counter advances from one of two sources, chosen by a static mode input that changes only while the block is held in reset. In time-base mode every instruction-cycle strobe enters a 2-bit divide-by-4 prescaler, and each prescaler carry bumps the counter, so the pair behaves as a 10-bit timer. In event mode an external pin is synchronised, sampled once per instruction cycle, and each qualified high-to-low transition advances the counter directly.

Software presets the counter through a transfer strobe, which also clears the prescaler, and reads a sticky wrap flag that it clears explicitly. Presetting to 256 minus N and waiting for the flag gives a timeout of N counter steps, which is 4 to 1024 instruction cycles in time-base mode. Issuing the interval-test instruction while in event mode is illegal; the block answers with a one-cycle error strobe.

Top module: `cycle_timer`

## Requirements
- R1: After reset count_o is 0x00, ovf_o is 0 and err_o is 0.
- R2: With mode_event_i = 0, count_o rises by one on every fourth clock in which tick_i is 1, counted since reset or the last load; clocks without tick_i do not advance the prescaler.
- R3: A clock with load_i = 1 puts load_val_i on count_o at the next edge and clears the prescaler, so the next increment needs four further ticks.
- R4: When load_i coincides with an increment, the loaded value is kept and the increment is dropped.
- R5: An increment from 0xFF to 0x00 sets ovf_o at that edge, in either mode; ovf_o then stays 1 until a clock with ovf_clr_i = 1 clears it.
- R6: If a wrap and ovf_clr_i occur in the same clock, ovf_o stays 1.
- R7: A load never sets ovf_o, even when it replaces an increment at 0xFF.
- R8: With mode_event_i = 1, ev_pin_i passes a two-stage synchroniser and is sampled on each tick_i; the counter rises by one when the samples read high, low, low in that order, so a low level lasting at least two ticks counts exactly once however long it lasts.
- R9: With mode_event_i = 1, a low level on ev_pin_i seen by only one tick sample does not advance the counter.
- R10: With mode_event_i = 1, tick_i alone (ev_pin_i held high) does not advance the counter.
- R11: A clock with itest_i = 1 raises err_o for exactly the following clock when mode_event_i = 1, and leaves err_o at 0 when mode_event_i = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-clock instruction-cycle strobe |
| mode_event_i | input | 1 | 0: time-base, 1: event counting; static outside reset |
| ev_pin_i | input | 1 | External event input, asynchronous |
| load_i | input | 1 | Transfer strobe: preset counter, clear prescaler |
| load_val_i | input | 8 | Value preset into the counter |
| ovf_clr_i | input | 1 | Clears the sticky wrap flag |
| itest_i | input | 1 | Interval-test instruction issued |
| count_o | output | 8 | Current counter value |
| ovf_o | output | 1 | Sticky wrap flag |
| err_o | output | 1 | One-clock illegal-instruction strobe |

## Verification
The assertions take for granted that mode_event_i holds its value whenever reset is released and that tick_i is a plain strobe, so that one prescaler step or one pin sample happens per clock in which it is high. The bench changes the mode only while rst_n is low, drives every input half a cycle away from the active edge, and times event pulses in whole tick periods, with ticks either continuous or separated by idle clocks, so each expected count follows from the sample pattern alone.

// File: rtl/cycle_timer_pkg.sv
package cycle_timer_pkg;

    typedef enum logic {
        MODE_TIMEBASE = 1'b0,
        MODE_EVENT    = 1'b1
    } timer_mode_e;

    function automatic logic is_event_mode(input logic mode_bit);
        return timer_mode_e'(mode_bit) == MODE_EVENT;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic clr_i,
    output logic carry_o
);
    localparam logic [PRE_W-1:0] PRE_MAX = '1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i || !en_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        carry_o = en_i && tick_i && (st_q.cnt == PRE_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> st_q.cnt == '0);

    // R2
    presc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && !clr_i) |=> st_q.cnt == $past(st_q.cnt) + 1'b1);

    // R2
    presc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i && !clr_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/tmr_event_qual.sv
module tmr_event_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic tick_i,
    output logic pulse_o
);
    localparam int SYNC_MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   older;
        logic                   newer;
    } ev_state_t;

    ev_state_t st_d, st_q;
    logic      sample;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_comb begin
                st_d      = st_q;
                st_d.sync = pin_i;
                sample    = st_q.sync[SYNC_MSB];
                if (tick_i) begin
                    st_d.older = st_q.newer;
                    st_d.newer = sample;
                end
                pulse_o = tick_i && st_q.older && !st_q.newer && !sample;
            end
        end else begin : g_chain
            always_comb begin
                st_d      = st_q;
                st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_i};
                sample    = st_q.sync[SYNC_MSB];
                if (tick_i) begin
                    st_d.older = st_q.newer;
                    st_d.newer = sample;
                end
                pulse_o = tick_i && st_q.older && !st_q.newer && !sample;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    ev_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    // R9
    ev_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.older) && $stable(st_q.newer));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        wrap = inc_i && !load_i && (st_q.cnt == CNT_MAX);
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (inc_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (ovf_clr_i) begin
            st_d.ovf = 1'b0;
        end
        if (wrap) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;

    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_o == $past(load_val_i));

    // R5
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i && cnt_o == CNT_MAX) |=> ovf_o && cnt_o == '0);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);

    // R7
    load_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !ovf_o) |=> !ovf_o);

    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !load_i) |=> $stable(cnt_o));

endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
    import cycle_timer_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             mode_event_i,
    input  logic             ev_pin_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             ovf_clr_i,
    input  logic             itest_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             err_o
);
    typedef struct packed {
        logic err;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       ev_mode;
    logic       presc_carry;
    logic       ev_pulse;
    logic       cnt_inc;

    tmr_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (!ev_mode),
        .tick_i  (tick_i),
        .clr_i   (load_i),
        .carry_o (presc_carry)
    );

    tmr_event_qual #(.SYNC_STAGES(SYNC_STAGES)) u_evq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (ev_pin_i),
        .tick_i  (tick_i),
        .pulse_o (ev_pulse)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (cnt_inc),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .ovf_clr_i  (ovf_clr_i),
        .cnt_o      (count_o),
        .ovf_o      (ovf_o)
    );

    always_comb begin
        ev_mode  = is_event_mode(mode_event_i);
        cnt_inc  = ev_mode ? ev_pulse : presc_carry;
        st_d     = st_q;
        st_d.err = itest_i && ev_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = st_q.err;

    // R11
    err_only_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(itest_i) && $past(mode_event_i));

    // R11
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !$past(itest_i, 1)) |-> 1'b0);

    // R10
    tick_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_event_i && !ev_pulse && !load_i) |=> $stable(count_o));

endmodule

// File: tb/cycle_timer_tb.sv
module cycle_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_i;
    logic       mode_event_i;
    logic       ev_pin_i;
    logic       load_i;
    logic [7:0] load_val_i;
    logic       ovf_clr_i;
    logic       itest_i;
    logic [7:0] count_o;
    logic       ovf_o;
    logic       err_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    cycle_timer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .mode_event_i (mode_event_i),
        .ev_pin_i     (ev_pin_i),
        .load_i       (load_i),
        .load_val_i   (load_val_i),
        .ovf_clr_i    (ovf_clr_i),
        .itest_i      (itest_i),
        .count_o      (count_o),
        .ovf_o        (ovf_o),
        .err_o        (err_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic ev);
        @(negedge clk);
        rst_n = 1'b0; mode_event_i = ev; tick_i = 1'b0; ev_pin_i = 1'b1;
        load_i = 1'b0; load_val_i = 8'h00; ovf_clr_i = 1'b0; itest_i = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1; step(1);
            tick_i = 1'b0; step(gap);
        end
    endtask

    task automatic preset(input logic [7:0] v);
        load_i = 1'b1; load_val_i = v; step(1);
        load_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        check("R1", "count after reset", count_o, 0);
        check("R1", "ovf after reset", ovf_o, 0);
        check("R1", "err after reset", err_o, 0);
    endtask

    task automatic t_timebase();
        do_reset(1'b0);
        ticks(3, 0);
        check("R2", "3 ticks", count_o, 0);
        ticks(1, 0);
        check("R2", "4 ticks", count_o, 1);
        ticks(8, 2);
        check("R2", "sparse ticks", count_o, 3);
        step(10);
        check("R2", "idle clocks", count_o, 3);
        ticks(40, 0);
        check("R2", "40 ticks", count_o, 13);
    endtask

    task automatic t_load();
        do_reset(1'b0);
        ticks(2, 0);
        preset(8'h40);
        check("R3", "loaded value", count_o, 8'h40);
        ticks(3, 0);
        check("R3", "prescaler cleared", count_o, 8'h40);
        ticks(1, 0);
        check("R3", "first step after load", count_o, 8'h41);
    endtask

    task automatic t_load_wins();
        do_reset(1'b0);
        preset(8'h10);
        ticks(3, 0);
        tick_i = 1'b1; load_i = 1'b1; load_val_i = 8'h80; step(1);
        tick_i = 1'b0; load_i = 1'b0;
        check("R4", "load beats carry", count_o, 8'h80);
        ticks(3, 0);
        check("R4", "no carry after tie", count_o, 8'h80);
        ticks(1, 0);
        check("R4", "step after tie", count_o, 8'h81);
    endtask

    task automatic t_overflow();
        do_reset(1'b0);
        preset(8'hFF);
        ticks(4, 0);
        check("R5", "wrap count", count_o, 0);
        check("R5", "wrap flag", ovf_o, 1);
        ticks(8, 0);
        check("R5", "flag sticky", ovf_o, 1);
        check("R5", "count after wrap", count_o, 2);
        ovf_clr_i = 1'b1; step(1); ovf_clr_i = 1'b0;
        check("R5", "flag cleared", ovf_o, 0);
        preset(8'hFF);
        ticks(3, 0);
        tick_i = 1'b1; ovf_clr_i = 1'b1; step(1);
        tick_i = 1'b0; ovf_clr_i = 1'b0;
        check("R6", "set beats clear", ovf_o, 1);
        ovf_clr_i = 1'b1; step(1); ovf_clr_i = 1'b0;
        preset(8'hFF);
        ticks(3, 0);
        tick_i = 1'b1; load_i = 1'b1; load_val_i = 8'h05; step(1);
        tick_i = 1'b0; load_i = 1'b0;
        check("R7", "load at FF count", count_o, 5);
        check("R7", "load at FF no flag", ovf_o, 0);
        preset(8'h00);
        check("R7", "load 00 no flag", ovf_o, 0);
    endtask

    task automatic low_pulse(input int clocks);
        ev_pin_i = 1'b0; step(clocks);
        ev_pin_i = 1'b1; step(8);
    endtask

    task automatic t_event();
        do_reset(1'b1);
        tick_i = 1'b1;
        step(40);
        check("R10", "ticks alone", count_o, 0);
        low_pulse(4);
        check("R8", "one qualified edge", count_o, 1);
        low_pulse(30);
        check("R8", "long low counts once", count_o, 2);
        low_pulse(1);
        check("R9", "single low sample", count_o, 2);
        low_pulse(2);
        check("R8", "two low samples", count_o, 3);
        preset(8'hFF);
        low_pulse(3);
        check("R5", "event wrap count", count_o, 0);
        check("R5", "event wrap flag", ovf_o, 1);
        tick_i = 1'b0;
    endtask

    task automatic t_event_slow_tick();
        do_reset(1'b1);
        ticks(4, 3);
        ev_pin_i = 1'b0; step(3);
        ev_pin_i = 1'b1;
        ticks(4, 3);
        check("R9", "low between ticks", count_o, 0);
        ev_pin_i = 1'b0;
        ticks(3, 3);
        ev_pin_i = 1'b1;
        ticks(4, 3);
        check("R8", "slow tick qualified", count_o, 1);
    endtask

    task automatic t_itest();
        do_reset(1'b0);
        itest_i = 1'b1; step(1); itest_i = 1'b0;
        check("R11", "no err in time-base", err_o, 0);
        step(1);
        check("R11", "no err later", err_o, 0);
        do_reset(1'b1);
        itest_i = 1'b1; step(1); itest_i = 1'b0;
        check("R11", "err in event mode", err_o, 1);
        step(1);
        check("R11", "err one clock", err_o, 0);
    endtask

    initial begin
        rst_n = 1'b0; mode_event_i = 1'b0; tick_i = 1'b0; ev_pin_i = 1'b1;
        load_i = 1'b0; load_val_i = 8'h00; ovf_clr_i = 1'b0; itest_i = 1'b0;
        t_reset();
        t_timebase();
        t_load();
        t_load_wins();
        t_overflow();
        t_event();
        t_event_slow_tick();
        t_itest();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        step(100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule